// File: doc/BRIEF.md
# Gated 16-bit Timer with Prescaler

This block is a 16-bit up-counter for use as a general-purpose timer. It counts one of two sources. The first is an internal tick, a one-cycle pulse at the instruction rate. The second is rising edges on an external clock pin. Before a source event reaches the counter it passes through a divide-by-1/2/4/8 prescaler. An active-low gate pin can pause counting when the gate is enabled. When the count wraps from 0xFFFF to 0x0000 the block sets a sticky overflow flag, which feeds the peripheral interrupt group.

Software uses the timer through a small byte-wide register file:

| Address | Register |
|---|---|
| 0 | control |
| 1 | count, low byte |
| 2 | count, high byte |
| 3 | overflow flag |

Reads are combinational. The two count bytes are read separately, so software that reads both must allow for the low byte wrapping between the two reads. External edges can be taken through a two-flop synchronizer, or through the shorter single-flop path for lower latency.

Top module: `gated_timer16`

## Requirements
- R1: After reset the control register, the count and the overflow flag read 0. Addresses are: 0 control, 1 count low byte, 2 count high byte, 3 flag (bit 0). Control bits are: bit 0 run, bit 1 ext_sel, bit 2 no_sync, bits 5:4 prescale, bit 6 gate_en. Control bits 7 and 3 read 0.
- R2: With run = 0 the count does not change, whatever happens on either source.
- R3: The prescale field divides source events by the following amounts, and the count changes by at most 1 per cycle. 00 divides by 1, 01 by 2, 10 by 4 and 11 by 8.
- R4: With ext_sel = 0 the timer counts tick_i pulses, and activity on ext_clk_i has no effect.
- R5: With gate_en = 1 and run = 1, events are counted only while gate_ni is low.
- R6: With gate_en = 0 the level of gate_ni has no effect on counting.
- R7: With ext_sel = 1 the timer counts rising edges of ext_clk_i, and tick_i has no effect. With no_sync = 0 the increment lands on the third clock edge after the pin rises. With no_sync = 1 it lands on the second.
- R8: The wrap from 0xFFFF to 0x0000 sets the flag. The flag stays set until a write to address 3 with bit 0 = 1, and a wrap in the same cycle as that write wins.
- R9: A write to either count byte loads that byte and keeps the other byte. It also clears the prescaler, and it takes priority over an increment in the same cycle.
- R10: Count reads are live and not latched: reading the high byte, then the low byte after a low-byte wrap, returns the old high byte with the new low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Internal instruction-rate tick, one-cycle pulse |
| ext_clk_i | input | 1 | External clock pin |
| gate_ni | input | 1 | Count gate, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Combinational read data |
| ovf_o | output | 1 | Overflow flag |

## Verification
A wrong prescaler state shows up as an off-by-one count. This is visible at the count registers after at most eight source events, and a stale prescaler after a count write shows within the next divide period. A broken synchronizer path shifts the increment by one cycle. The bench therefore samples the count on the exact second and third edges after the pin rises. A fault in the wrap logic shows at ovf_o one cycle after the 0xFFFF increment, and the flag must then hold across later increments.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    A_CTRL   = 2'd0,
    A_CNT_LO = 2'd1,
    A_CNT_HI = 2'd2,
    A_FLAG   = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic       rsv7;
    logic       gate_en;
    logic [1:0] psc;
    logic       rsv3;
    logic       no_sync;
    logic       ext_sel;
    logic       run;
  } ctrl_t;

  localparam logic [7:0] CTRL_MASK = 8'h77;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic bypass_i,
  output logic rise_o
);
  logic [STAGES-1:0] sq;
  logic              src, src_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sq <= '0;
        else         sq <= pin_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sq <= '0;
        else         sq <= {sq[STAGES-2:0], pin_i};
    end
  endgenerate

  // bypass takes the first capture flop only
  assign src = bypass_i ? sq[0] : sq[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) src_d <= 1'b0;
    else         src_d <= src;

  assign rise_o = src & ~src_d;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PS_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            ev_i,
  input  logic [PS_W-1:0] sel_i,
  output logic            fire_o
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] cnt_q, mask;

  always_comb
    for (int i = 0; i < DIV_W; i++) mask[i] = (i < int'(sel_i));

  assign fire_o = ev_i && ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (fire_o) cnt_q <= '0;
    else if (ev_i)   cnt_q <= cnt_q + 1'b1;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_lo_i,
  input  logic         we_hi_i,
  input  logic [7:0]   wdata_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else if (we_lo_i || we_hi_i) begin
      if (we_lo_i) cnt_q[7:0]     <= wdata_i;
      if (we_hi_i) cnt_q[W-1:W-8] <= wdata_i;
    end else if (inc_i) cnt_q <= cnt_q + 1'b1;

  assign cnt_o  = cnt_q;
  assign wrap_o = inc_i && !(we_lo_i || we_hi_i) && (&cnt_q);
endmodule

// File: rtl/gated_timer16.sv
module gated_timer16
  import tmr_pkg::*;
#(
  parameter int PS_W        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       ext_clk_i,
  input  logic       gate_ni,
  input  logic       wr_en_i,
  input  logic [1:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic [1:0] rd_addr_i,
  output logic [7:0] rd_data_o,
  output logic       ovf_o
);
  localparam int CNT_W = 16;

  ctrl_t            ctrl_q;
  logic             ovf_q;
  logic [CNT_W-1:0] cnt;
  logic             ext_rise, src_ev, gate_open, ev_q, fire, wrap;
  logic             we_ctrl, we_lo, we_hi, we_flag;

  assign we_ctrl = wr_en_i && (wr_addr_i == A_CTRL);
  assign we_lo   = wr_en_i && (wr_addr_i == A_CNT_LO);
  assign we_hi   = wr_en_i && (wr_addr_i == A_CNT_HI);
  assign we_flag = wr_en_i && (wr_addr_i == A_FLAG);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      ctrl_q <= '0;
    else if (we_ctrl) ctrl_q <= ctrl_t'(wr_data_i & CTRL_MASK);

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_i    (ext_clk_i),
    .bypass_i (ctrl_q.no_sync),
    .rise_o   (ext_rise)
  );

  assign src_ev    = ctrl_q.ext_sel ? ext_rise : tick_i;
  assign gate_open = !ctrl_q.gate_en || !gate_ni;
  assign ev_q      = ctrl_q.run && gate_open && src_ev;

  tmr_prescaler #(.PS_W(PS_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (we_lo || we_hi),
    .ev_i   (ev_q),
    .sel_i  (ctrl_q.psc),
    .fire_o (fire)
  );

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_lo_i (we_lo),
    .we_hi_i (we_hi),
    .wdata_i (wr_data_i),
    .inc_i   (fire),
    .cnt_o   (cnt),
    .wrap_o  (wrap)
  );

  // wrap beats a software clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                        ovf_q <= 1'b0;
    else if (wrap)                      ovf_q <= 1'b1;
    else if (we_flag && wr_data_i[0])   ovf_q <= 1'b0;

  assign ovf_o = ovf_q;

  always_comb
    unique case (rd_addr_i)
      A_CTRL:   rd_data_o = ctrl_q;
      A_CNT_LO: rd_data_o = cnt[7:0];
      A_CNT_HI: rd_data_o = cnt[CNT_W-1:CNT_W-8];
      default:  rd_data_o = {7'd0, ovf_q};
    endcase
endmodule

// File: rtl/gated_timer16_chk.sv
module gated_timer16_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        gate_ni,
  input logic        run,
  input logic        gate_en,
  input logic [15:0] count,
  input logic        ovf
);
  // R2
  a_r2_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !wr_en_i) |=> $stable(count));

  // R5
  a_r5_gate_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && gate_en && gate_ni && !wr_en_i) |=> $stable(count));

  // R3
  a_r3_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (count == $past(count) || count == $past(count) + 16'd1));

  // R8
  a_r8_wrap_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && count == 16'hFFFF) |=> (count == 16'hFFFF || ovf));

  // R8
  a_r8_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf && !wr_en_i) |=> ovf);
endmodule

bind gated_timer16 gated_timer16_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .gate_ni (gate_ni),
  .run     (ctrl_q.run),
  .gate_en (ctrl_q.gate_en),
  .count   (cnt),
  .ovf     (ovf_q)
);

// File: tb/sim_gated_timer16.sv
module sim_gated_timer16;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0, ext_clk_i = 1'b0, gate_ni = 1'b1;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0, rd_addr_i = '0;
  logic [7:0] wr_data_i = '0, rd_data_o;
  logic       ovf_o;
  int         checks = 0, errors = 0;
  logic       done = 1'b0;

  always #10 clk_i = ~clk_i;

  gated_timer16 u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    rd_addr_i = a; #1; d = rd_data_o;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] h, l;
    rd(2'd2, h); rd(2'd1, l); v = {h, l};
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i) tick_i = 1'b1;
      @(negedge clk_i) tick_i = 1'b0;
    end
  endtask

  task automatic load(logic [15:0] v);
    wr(2'd1, v[7:0]); wr(2'd2, v[15:8]);
  endtask

  task automatic t_reset;
    logic [7:0] d; logic [15:0] v;
    rd(2'd0, d); chk("R1 ctrl reset", d, 0);
    rd16(v);     chk("R1 count reset", v, 0);
    rd(2'd3, d); chk("R1 flag reset", d, 0);
    chk("R1 ovf_o reset", ovf_o, 0);
    wr(2'd0, 8'hFF); rd(2'd0, d); chk("R1 reserved bits", d, 8'h77);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_run_off;
    logic [15:0] v;
    load(16'h0042);
    ticks(5);
    rd16(v); chk("R2 no count when off", v, 16'h0042);
    wr(2'd0, 8'h01);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i) ext_clk_i = 1'b1;
      repeat (3) @(negedge clk_i);
      ext_clk_i = 1'b0;
      repeat (3) @(negedge clk_i);
    end
    rd16(v); chk("R4 ext pin ignored on internal", v, 16'h0042);
    ticks(3);
    rd16(v); chk("R4 internal ticks count", v, 16'h0045);
  endtask

  task automatic t_prescale;
    logic [15:0] v;
    for (int ps = 0; ps < 4; ps++) begin
      wr(2'd0, 8'h01 | 8'(ps << 4));
      load(16'h0000);
      ticks(16);
      rd16(v); chk("R3 prescale divide", v, 32'(16 >> ps));
    end
  endtask

  task automatic t_gate;
    logic [15:0] v;
    wr(2'd0, 8'h41); load(16'h0000);
    gate_ni = 1'b1; ticks(4);
    rd16(v); chk("R5 gate high blocks", v, 0);
    gate_ni = 1'b0; ticks(4);
    rd16(v); chk("R5 gate low counts", v, 4);
    wr(2'd0, 8'h01);
    gate_ni = 1'b1; ticks(4);
    rd16(v); chk("R6 gate ignored when disabled", v, 8);
  endtask

  task automatic t_ext;
    logic [15:0] v;
    wr(2'd0, 8'h03); load(16'h0000);
    tick_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i) ext_clk_i = 1'b1;
      repeat (4) @(negedge clk_i);
      ext_clk_i = 1'b0;
      repeat (4) @(negedge clk_i);
    end
    tick_i = 1'b0;
    repeat (4) @(negedge clk_i);
    rd16(v); chk("R7 ext edges counted, tick ignored", v, 5);
  endtask

  task automatic t_sync;
    logic [15:0] v;
    // unsynchronized: lands on 2nd edge
    wr(2'd0, 8'h07); load(16'h0000);
    repeat (4) @(negedge clk_i);
    ext_clk_i = 1'b1;
    @(negedge clk_i); rd16(v); chk("R7 nosync after 1 edge", v, 0);
    @(negedge clk_i); rd16(v); chk("R7 nosync after 2 edges", v, 1);
    ext_clk_i = 1'b0;
    repeat (4) @(negedge clk_i);
    // synchronized: lands on 3rd edge
    wr(2'd0, 8'h03); load(16'h0000);
    repeat (4) @(negedge clk_i);
    ext_clk_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i); rd16(v); chk("R7 sync after 2 edges", v, 0);
    @(negedge clk_i); rd16(v); chk("R7 sync after 3 edges", v, 1);
    ext_clk_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_overflow;
    logic [15:0] v; logic [7:0] d;
    wr(2'd0, 8'h00); load(16'hFFFE); wr(2'd0, 8'h01);
    ticks(1);
    rd16(v); chk("R8 at FFFF", v, 16'hFFFF);
    chk("R8 no flag before wrap", ovf_o, 0);
    ticks(1);
    rd16(v); chk("R8 wrapped to 0", v, 0);
    chk("R8 flag set on wrap", ovf_o, 1);
    ticks(1);
    chk("R8 flag sticky", ovf_o, 1);
    wr(2'd3, 8'h00); chk("R8 write 0 keeps flag", ovf_o, 1);
    wr(2'd3, 8'h01); rd(2'd3, d);
    chk("R8 flag cleared", d, 0);
  endtask

  task automatic t_rollover;
    logic [7:0] h, l, h2;
    wr(2'd0, 8'h00); load(16'h12FF); wr(2'd0, 8'h01);
    rd(2'd2, h);
    ticks(1);
    rd(2'd1, l);
    chk("R10 torn read", {h, l}, 16'h1200);
    rd(2'd2, h2);
    chk("R10 live high byte", h2, 8'h13);
  endtask

  task automatic t_psc_clear;
    logic [15:0] v;
    wr(2'd0, 8'h31); load(16'h0000);
    ticks(5);
    wr(2'd1, 8'h00);
    ticks(7);
    rd16(v); chk("R9 write clears prescaler", v, 0);
    ticks(1);
    rd16(v); chk("R9 full period after clear", v, 1);
    wr(2'd0, 8'h01); load(16'hAB00);
    wr(2'd1, 8'h34);
    rd16(v); chk("R9 low write keeps high", v, 16'hAB34);
    // write during tick wins
    @(negedge clk_i);
    tick_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 2'd1; wr_data_i = 8'h10;
    @(negedge clk_i);
    tick_i = 1'b0; wr_en_i = 1'b0;
    rd16(v); chk("R9 write beats increment", v, 16'hAB10);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_run_off();
    t_prescale();
    t_gate();
    t_ext();
    t_sync();
    t_overflow();
    t_rollover();
    t_psc_clear();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule